// File: doc/BRIEF.md
# Coefficient Set Configuration Scheduler

This block decides which coefficient set each interleaved channel of a multi-channel filter uses. A configuration packet arrives on a stream-style CONFIG channel carrying set indices. The block keeps that packet waiting, and loses nothing, until the data stream reaches a point where a change is allowed. That point is the accepted first sample of an interleaved vector. In packet synchronisation mode it must also follow an accepted beat that carried TLAST. When the packet is taken, the new indices are registered as the active sets.

The same event commits reloaded coefficient slots. A reload source reports "slot filled" events with a slot index, and the block marks those slots as staged. Consuming a configuration emits a one-cycle commit strobe together with the mask of the staged slots, then clears the staged mask. Refilling a slot that is still staged replaces its contents and sets a sticky overflow flag. The block only observes the data handshake; it never drives the data path.

Top module: `cfgs_sched`

## Requirements
- R1: `cfg_tready` is 1 only in a cycle with an accepted data beat (`dat_valid` and `dat_ready` both 1) whose vector position is 0. With one channel, every accepted beat qualifies. A packet offered at any other time stays pending until such a cycle.
- R2: In packet synchronisation mode, `cfg_tready` also requires that an accepted beat with `dat_last`=1 has occurred since reset or since the last consumed configuration.
- R3: The TLAST-seen condition is set by an accepted beat with `dat_last`=1 and cleared by a consumed configuration. If one beat both consumes and carries TLAST, the condition is set again.
- R4: In per-channel mode, the cycle after a consume, channel c's active set `act_set[c*SET_W +: SET_W]` equals `cfg_tdata[c*SET_W +: SET_W]` of the consumed packet.
- R5: In shared mode, the cycle after a consume, every channel's active set equals `cfg_tdata[SET_W-1:0]`. The upper bits of `cfg_tdata` are ignored.
- R6: `act_set` does not change in any cycle that follows a cycle with no consume (consume means `cfg_tvalid` and `cfg_tready` both 1).
- R7: `rld_fill`=1 sets bit `rld_slot` of `staged_mask`, visible in the next cycle.
- R8: The cycle after a consume, `commit_stb`=1 and `commit_mask` equals `staged_mask` as it stood in the consume cycle. `staged_mask` then holds only a slot filled in that same cycle. In every other cycle `commit_stb`=0 and `commit_mask`=0.
- R9: A fill into a slot whose `staged_mask` bit is already 1, in a cycle with no consume, sets `reload_ovf` the next cycle. `reload_ovf` stays 1 until reset.
- R10: While `rst_n`=0 and after it is released: `act_set`, `vec_pos`, `staged_mask`, `commit_stb`, `commit_mask` and `reload_ovf` are all 0, and the TLAST-seen condition is clear.
- R11: `vec_pos` advances by one on each accepted data beat and wraps from NUM_CH-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dat_valid | input | 1 | Data channel valid (observed) |
| dat_ready | input | 1 | Data channel ready (observed) |
| dat_last | input | 1 | Data channel TLAST (observed) |
| cfg_tvalid | input | 1 | Configuration packet valid |
| cfg_tready | output | 1 | Configuration packet accepted this cycle |
| cfg_tdata | input | NUM_CH*SET_W | Set indices, field c for channel c |
| rld_fill | input | 1 | A reload slot was filled |
| rld_slot | input | SLOT_W | Index of the filled slot |
| act_set | output | NUM_CH*SET_W | Active set index per channel |
| vec_pos | output | POS_W | Channel position of the next data beat |
| commit_stb | output | 1 | One-cycle commit of staged slots |
| commit_mask | output | NUM_SLOTS | Slots committed by this strobe |
| staged_mask | output | NUM_SLOTS | Slots filled and not yet committed |
| reload_ovf | output | 1 | Sticky: a staged slot was refilled |

## Verification
The assertions check on every cycle that acceptance happens only on a position-0 beat, and in packet mode only with TLAST seen. They also check that the active sets hold outside consumes, that the commit strobe follows exactly the consume cycles, that staged slots clear on commit, and that overflow is sticky and has a legal cause. Only the bench scenarios show the actual values. These are the per-channel and shared field mapping, the exact committed mask, the re-arming of the TLAST condition by a consuming TLAST beat, and a packet held for many cycles that is finally taken. The bench compares three configurations against its own model: four-channel per-channel vector mode, four-channel shared packet mode, and single-channel mode.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;

    typedef enum logic {
        SYNC_VECTOR = 1'b0,
        SYNC_PACKET = 1'b1
    } sync_e;

    typedef enum logic {
        SET_SHARED = 1'b0,
        SET_PER_CH = 1'b1
    } setmode_e;

endpackage

// File: rtl/cfgs_vec_track.sv
module cfgs_vec_track #(
    parameter int               NUM_CH = 4,
    parameter cfgs_pkg::sync_e  SYNC   = cfgs_pkg::SYNC_VECTOR,
    localparam int              POS_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dat_fire,
    input  logic             dat_last,
    input  logic             consume,
    output logic [POS_W-1:0] pos,
    output logic             seen,
    output logic             sync_ok
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(NUM_CH - 1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             seen;
    } trk_t;

    trk_t st_d, st_q;
    logic gate_ok;

    always_comb begin
        st_d    = st_q;
        gate_ok = (SYNC == cfgs_pkg::SYNC_VECTOR) || st_q.seen;
        sync_ok = dat_fire && (st_q.pos == '0) && gate_ok;

        if (dat_fire) begin
            if (st_q.pos == LAST_POS) st_d.pos = '0;
            else                      st_d.pos = st_q.pos + 1'b1;
        end

        st_d.seen = (st_q.seen && !consume) || (dat_fire && dat_last);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pos  = st_q.pos;
    assign seen = st_q.seen;
endmodule

// File: rtl/cfgs_slot_stage.sv
module cfgs_slot_stage #(
    parameter int  NUM_SLOTS = 8,
    localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fill,
    input  logic [SLOT_W-1:0]    slot,
    input  logic                 consume,
    output logic [NUM_SLOTS-1:0] staged,
    output logic                 commit_stb,
    output logic [NUM_SLOTS-1:0] commit_mask,
    output logic                 ovf
);
    typedef struct packed {
        logic [NUM_SLOTS-1:0] staged;
        logic [NUM_SLOTS-1:0] cmask;
        logic                 cstb;
        logic                 ovf;
    } stg_t;

    stg_t st_d, st_q;
    logic [NUM_SLOTS-1:0] fill_oh;
    logic                 hit;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_oh
        assign fill_oh[i] = fill && (slot == SLOT_W'(i));
    end

    assign hit = |(fill_oh & st_q.staged);

    always_comb begin
        st_d      = st_q;
        st_d.cstb = consume;
        if (consume) begin
            st_d.cmask  = st_q.staged;
            st_d.staged = fill_oh;
        end else begin
            st_d.cmask  = '0;
            st_d.staged = st_q.staged | fill_oh;
            if (hit) st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign staged      = st_q.staged;
    assign commit_stb  = st_q.cstb;
    assign commit_mask = st_q.cmask;
    assign ovf         = st_q.ovf;
endmodule

// File: rtl/cfgs_set_bank.sv
module cfgs_set_bank #(
    parameter int                 NUM_CH = 4,
    parameter int                 SET_W  = 3,
    parameter cfgs_pkg::setmode_e MODE   = cfgs_pkg::SET_PER_CH,
    localparam int                ALL_W  = NUM_CH * SET_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             consume,
    input  logic [ALL_W-1:0] cfg_data,
    output logic [ALL_W-1:0] sets
);
    typedef struct packed {
        logic [ALL_W-1:0] sets;
    } bank_t;

    bank_t st_d, st_q;
    logic [ALL_W-1:0] pick;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        if (MODE == cfgs_pkg::SET_PER_CH) begin : g_own
            assign pick[c*SET_W +: SET_W] = cfg_data[c*SET_W +: SET_W];
        end else begin : g_shared
            assign pick[c*SET_W +: SET_W] = cfg_data[SET_W-1:0];
        end
    end

    always_comb begin
        st_d = st_q;
        if (consume) st_d.sets = pick;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sets = st_q.sets;
endmodule

// File: rtl/cfgs_sched.sv
module cfgs_sched #(
    parameter int                 NUM_CH    = 4,
    parameter int                 SET_W     = 3,
    parameter int                 NUM_SLOTS = 8,
    parameter cfgs_pkg::sync_e    SYNC      = cfgs_pkg::SYNC_VECTOR,
    parameter cfgs_pkg::setmode_e MODE      = cfgs_pkg::SET_PER_CH,
    localparam int                SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int                POS_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int                ALL_W     = NUM_CH * SET_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dat_valid,
    input  logic                 dat_ready,
    input  logic                 dat_last,
    input  logic                 cfg_tvalid,
    output logic                 cfg_tready,
    input  logic [ALL_W-1:0]     cfg_tdata,
    input  logic                 rld_fill,
    input  logic [SLOT_W-1:0]    rld_slot,
    output logic [ALL_W-1:0]     act_set,
    output logic [POS_W-1:0]     vec_pos,
    output logic                 commit_stb,
    output logic [NUM_SLOTS-1:0] commit_mask,
    output logic [NUM_SLOTS-1:0] staged_mask,
    output logic                 reload_ovf
);
    logic dat_fire;
    logic sync_ok;
    logic consume;
    logic seen_q;

    assign dat_fire   = dat_valid && dat_ready;
    assign cfg_tready = sync_ok;
    assign consume    = sync_ok && cfg_tvalid;

    cfgs_vec_track #(
        .NUM_CH (NUM_CH),
        .SYNC   (SYNC)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .dat_fire (dat_fire),
        .dat_last (dat_last),
        .consume  (consume),
        .pos      (vec_pos),
        .seen     (seen_q),
        .sync_ok  (sync_ok)
    );

    cfgs_slot_stage #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_stage (
        .clk         (clk),
        .rst_n       (rst_n),
        .fill        (rld_fill),
        .slot        (rld_slot),
        .consume     (consume),
        .staged      (staged_mask),
        .commit_stb  (commit_stb),
        .commit_mask (commit_mask),
        .ovf         (reload_ovf)
    );

    cfgs_set_bank #(
        .NUM_CH (NUM_CH),
        .SET_W  (SET_W),
        .MODE   (MODE)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .consume  (consume),
        .cfg_data (cfg_tdata),
        .sets     (act_set)
    );
endmodule

// File: rtl/cfgs_sched_chk.sv
module cfgs_sched_chk #(
    parameter int               NUM_CH    = 4,
    parameter int               SET_W     = 3,
    parameter int               NUM_SLOTS = 8,
    parameter cfgs_pkg::sync_e  SYNC      = cfgs_pkg::SYNC_VECTOR,
    localparam int              SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int              POS_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int              ALL_W     = NUM_CH * SET_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 dat_valid,
    input logic                 dat_ready,
    input logic                 cfg_tvalid,
    input logic                 cfg_tready,
    input logic                 rld_fill,
    input logic [SLOT_W-1:0]    rld_slot,
    input logic [ALL_W-1:0]     act_set,
    input logic [POS_W-1:0]     vec_pos,
    input logic                 commit_stb,
    input logic [NUM_SLOTS-1:0] staged_mask,
    input logic                 reload_ovf,
    input logic                 seen_q
);
    logic take;
    assign take = cfg_tvalid && cfg_tready;

    AST_RDY_ON_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_tready |-> (dat_valid && dat_ready && vec_pos == '0)); // R1

    AST_PKT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_tready |-> (SYNC == cfgs_pkg::SYNC_VECTOR || seen_q)); // R2

    AST_SETS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(act_set)); // R6

    AST_COMMIT_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> commit_stb); // R8

    AST_NO_STRAY_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> !commit_stb); // R8

    AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !rld_fill) |=> (staged_mask == '0)); // R8

    AST_FILL_STAGES: assert property (@(posedge clk) disable iff (!rst_n)
        rld_fill |=> staged_mask[$past(rld_slot)]); // R7

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        reload_ovf |=> reload_ovf); // R9

    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reload_ovf) |-> $past(rld_fill && !take && staged_mask[rld_slot])); // R9

    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(vec_pos) < NUM_CH); // R11
endmodule

bind cfgs_sched cfgs_sched_chk #(
    .NUM_CH    (NUM_CH),
    .SET_W     (SET_W),
    .NUM_SLOTS (NUM_SLOTS),
    .SYNC      (SYNC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dat_valid   (dat_valid),
    .dat_ready   (dat_ready),
    .cfg_tvalid  (cfg_tvalid),
    .cfg_tready  (cfg_tready),
    .rld_fill    (rld_fill),
    .rld_slot    (rld_slot),
    .act_set     (act_set),
    .vec_pos     (vec_pos),
    .commit_stb  (commit_stb),
    .staged_mask (staged_mask),
    .reload_ovf  (reload_ovf),
    .seen_q      (seen_q)
);

// File: tb/tb_cfgs_sched.sv
`timescale 1ns/1ps
module tb_cfgs_sched;
    localparam int NCH = 4;
    localparam int SW  = 3;
    localparam int NS  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic       dv = 0, dr = 0, dl = 0, fill = 0;
    logic [2:0] slot = '0;
    logic       cv [3];
    logic [11:0] cd [3];

    logic [2:0]  rdy;
    logic [11:0] act_o [3];
    logic [1:0]  pos_o [3];
    logic [7:0]  stg_o [3];
    logic [7:0]  cm_o [3];
    logic [2:0]  cs_o, ov_o;

    logic [2:0] act2;
    logic       pos2;

    cfgs_sched #(.NUM_CH(NCH), .SET_W(SW), .NUM_SLOTS(NS),
                 .SYNC(cfgs_pkg::SYNC_VECTOR), .MODE(cfgs_pkg::SET_PER_CH)) dut (
        .clk(clk), .rst_n(rst_n), .dat_valid(dv), .dat_ready(dr), .dat_last(dl),
        .cfg_tvalid(cv[0]), .cfg_tready(rdy[0]), .cfg_tdata(cd[0]),
        .rld_fill(fill), .rld_slot(slot), .act_set(act_o[0]), .vec_pos(pos_o[0]),
        .commit_stb(cs_o[0]), .commit_mask(cm_o[0]), .staged_mask(stg_o[0]),
        .reload_ovf(ov_o[0]));

    cfgs_sched #(.NUM_CH(NCH), .SET_W(SW), .NUM_SLOTS(NS),
                 .SYNC(cfgs_pkg::SYNC_PACKET), .MODE(cfgs_pkg::SET_SHARED)) dut_pkt (
        .clk(clk), .rst_n(rst_n), .dat_valid(dv), .dat_ready(dr), .dat_last(dl),
        .cfg_tvalid(cv[1]), .cfg_tready(rdy[1]), .cfg_tdata(cd[1]),
        .rld_fill(fill), .rld_slot(slot), .act_set(act_o[1]), .vec_pos(pos_o[1]),
        .commit_stb(cs_o[1]), .commit_mask(cm_o[1]), .staged_mask(stg_o[1]),
        .reload_ovf(ov_o[1]));

    cfgs_sched #(.NUM_CH(1), .SET_W(SW), .NUM_SLOTS(NS),
                 .SYNC(cfgs_pkg::SYNC_VECTOR), .MODE(cfgs_pkg::SET_PER_CH)) dut_one (
        .clk(clk), .rst_n(rst_n), .dat_valid(dv), .dat_ready(dr), .dat_last(dl),
        .cfg_tvalid(cv[2]), .cfg_tready(rdy[2]), .cfg_tdata(cd[2][2:0]),
        .rld_fill(fill), .rld_slot(slot), .act_set(act2), .vec_pos(pos2),
        .commit_stb(cs_o[2]), .commit_mask(cm_o[2]), .staged_mask(stg_o[2]),
        .reload_ovf(ov_o[2]));

    assign act_o[2] = {9'd0, act2};
    assign pos_o[2] = {1'b0, pos2};

    // reference model
    int   nch [3] = '{4, 4, 1};
    bit   pkt [3] = '{0, 1, 0};
    bit   per [3] = '{1, 0, 1};
    int   m_pos [3];
    bit   m_seen [3];
    int   m_act [3][4];
    bit [7:0] m_stg [3], m_cm [3];
    bit   m_cs [3], m_ov [3], took [3];
    bit   after_rst;
    string rdy_tag = "R2";

    int checks = 0, fails = 0;
    bit done = 0;

    task automatic chk(string req, int k, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s inst=%0d got=%0h exp=%0h t=%0t", req, k, got, exp, $time);
        end
    endtask

    task automatic model_clear();
        for (int k = 0; k < 3; k++) begin
            m_pos[k] = 0; m_seen[k] = 0; m_stg[k] = 0; m_cm[k] = 0;
            m_cs[k] = 0; m_ov[k] = 0; took[k] = 1;
            for (int c = 0; c < 4; c++) m_act[k][c] = 0;
        end
    endtask

    function automatic logic [31:0] pack_act(int k);
        logic [31:0] v = 0;
        for (int c = 0; c < nch[k]; c++) v |= 32'(m_act[k][c]) << (3 * c);
        return v;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; dv = 0; dr = 0; dl = 0; fill = 0; slot = 0;
        for (int k = 0; k < 3; k++) begin cv[k] = 0; cd[k] = 0; end
        model_clear();
        repeat (3) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            chk("R10", k, {act_o[k], pos_o[k], stg_o[k], cm_o[k], cs_o[k], ov_o[k]}, 0);
        end
        rst_n = 1;
        after_rst = 1;
    endtask

    task automatic step(bit rnd, bit i_dv, bit i_dr, bit i_dl, bit i_fill,
                        logic [2:0] i_slot, bit i_cv, logic [11:0] i_cd);
        bit fire, okk, cons;
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            string ta;
            ta = m_cs[k] ? (per[k] ? "R4" : "R5") : "R6";
            if (after_rst) ta = "R10";
            chk(after_rst ? "R10" : "R11", k, pos_o[k], m_pos[k]);
            chk(ta, k, act_o[k], pack_act(k));
            chk(after_rst ? "R10" : "R7", k, stg_o[k], m_stg[k]);
            chk("R8", k, {cs_o[k], cm_o[k]}, {m_cs[k], m_cm[k]});
            chk("R9", k, ov_o[k], m_ov[k]);
        end
        after_rst = 0;
        if (rnd) begin
            dv = ($urandom % 4) != 0; dr = ($urandom % 3) != 0;
            dl = ($urandom % 5) == 0; fill = ($urandom % 6) == 0;
            slot = 3'($urandom);
        end else begin
            dv = i_dv; dr = i_dr; dl = i_dl; fill = i_fill; slot = i_slot;
        end
        for (int k = 0; k < 3; k++) begin
            if (took[k]) begin
                cv[k] = rnd ? (($urandom % 3) == 0) : i_cv;
                cd[k] = rnd ? 12'($urandom) : i_cd;
            end else if (!rnd && i_cv) begin
                cd[k] = cd[k];
            end
        end
        #1;
        fire = dv && dr;
        for (int k = 0; k < 3; k++) begin
            okk  = fire && (m_pos[k] == 0) && (!pkt[k] || m_seen[k]);
            cons = okk && cv[k];
            chk(pkt[k] ? rdy_tag : "R1", k, rdy[k], okk);
            m_cs[k] = cons;
            m_cm[k] = cons ? m_stg[k] : 8'd0;
            if (fill && !cons && m_stg[k][slot]) m_ov[k] = 1;
            m_stg[k] = (cons ? 8'd0 : m_stg[k]) | (fill ? (8'd1 << slot) : 8'd0);
            if (cons)
                for (int c = 0; c < nch[k]; c++)
                    m_act[k][c] = per[k] ? int'(cd[k][3*c +: 3]) : int'(cd[k][2:0]);
            m_seen[k] = (m_seen[k] && !cons) || (fire && dl);
            if (fire) m_pos[k] = (m_pos[k] == nch[k] - 1) ? 0 : m_pos[k] + 1;
            took[k] = cons || !cv[k];
        end
    endtask

    initial begin
        for (int k = 0; k < 3; k++) begin cv[k] = 0; cd[k] = 0; end
        void'($urandom(32'h5eed_c0de));
        do_reset();
        // directed: reset idle, then staging and overflow (R7, R9)
        step(0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 3'd2, 0, 0);
        step(0, 0, 0, 0, 1, 3'd5, 0, 0);
        step(0, 0, 0, 0, 1, 3'd2, 0, 0);
        // packet offered while data stalls: must wait (R1)
        step(0, 1, 0, 0, 0, 0, 1, 12'o7351);
        step(0, 0, 1, 0, 0, 0, 1, 12'o7351);
        // first beat: vector-mode instances consume (R4, R8)
        step(0, 1, 1, 0, 1, 3'd6, 1, 12'o7351);
        step(0, 1, 1, 0, 0, 0, 0, 0);
        step(0, 1, 1, 0, 0, 0, 0, 0);
        step(0, 1, 1, 1, 0, 0, 0, 0);
        // packet mode now armed by TLAST (R3)
        rdy_tag = "R3";
        step(0, 1, 1, 1, 0, 0, 1, 12'o0426);
        step(0, 1, 1, 0, 0, 0, 0, 0);
        step(0, 1, 1, 0, 0, 0, 0, 0);
        step(0, 1, 1, 0, 0, 0, 0, 0);
        // TLAST on consuming beat re-armed: next vector consumes again (R3)
        step(0, 1, 1, 0, 0, 0, 1, 12'o1115);
        step(0, 1, 1, 0, 0, 0, 0, 0);
        step(0, 1, 1, 0, 0, 0, 0, 0);
        step(0, 1, 1, 0, 0, 0, 0, 0);
        // cleared: no TLAST since, packet must wait (R3)
        step(0, 1, 1, 0, 0, 0, 1, 12'o6262);
        step(0, 1, 1, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        rdy_tag = "R2";
        do_reset();
        for (int i = 0; i < 4000; i++) step(1, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule